// File: doc/BRIEF.md
# Four-Mode Clock and Power Sequencer

This block decides which clocks of a small system-on-chip are running. It sits between two clock sources and the rest of the chip. The first source is a fast clock from a phase-locked loop. The second is a free-running low-frequency oscillator. From these it drives a gated CPU clock, one gated clock for each peripheral, and the enable line of the phase-locked loop. Software selects a power mode by writing a mode request. Each peripheral clock also has its own enable bit.

The sequencer is a state machine clocked by the oscillator. It has five states:
- `ST_NORMAL`: the CPU and the enabled peripherals run from the fast clock.
- `ST_SLOW`: the loop is switched off and everything runs from the oscillator.
- `ST_IDLE`: only the CPU clock is stopped.
- `ST_STOP`: every gated clock is stopped and the loop is off.
- `ST_RELOCK`: the loop has been re-enabled and the CPU clock is held off while a lock counter runs down.

The named transitions are:
- `NORMAL->SLOW`, `NORMAL->IDLE` and `NORMAL->STOP`, all on a request.
- `SLOW->RELOCK` on a request for Normal.
- `SLOW->STOP` on a request for Stop, which remembers that the stop came from Slow.
- `IDLE->NORMAL` on any pending enabled interrupt.
- `STOP->RELOCK` on a wake event, when the stop was entered from Normal.
- `STOP->SLOW` on a wake event, when the stop was entered from Slow.
- `RELOCK->NORMAL` when the lock counter expires.

Every gated clock passes through a gate whose enable is captured while that clock is low. An enable change therefore never shortens a high pulse.

Top module: `clk_power_seq`

## Requirements
- R1: After reset the status reads 0 (Normal), the loop enable is 1 and the CPU clock toggles at the fast-clock rate.
- R2: A request with `req_valid` high is taken on the next oscillator edge. Mode codes are 0 Normal, 1 Slow, 2 Idle and 3 Stop. `mode_stat` shows the state code, and 4 means relocking.
- R3: In Slow the loop enable is 0, and the CPU clock toggles at the oscillator rate.
- R4: In Idle the CPU clock is stopped, while enabled peripheral clocks keep toggling at the fast-clock rate.
- R5: In Stop no gated clock toggles and the loop enable is 0.
- R6: Stop is left only when `eint` is nonzero or `rtc_alarm` is high. `irq_pending` alone keeps the block in Stop.
- R7: In Idle, `irq_pending` high moves the block to Normal on the next oscillator edge.
- R8: On a wake from a Stop entered from Normal, the status reads 4 for exactly `lock_count`+1 oscillator cycles. During that time the loop enable is 1 and the CPU clock does not toggle. The block then returns to Normal.
- R9: On a wake from a Stop entered from Slow, the block returns directly to Slow without relocking.
- R10: Bit i of `periph_en` gates `periph_clk[i]` alone. A set bit lets that clock run and a clear bit stops it.
- R11: A request for Normal while in Slow passes through the relock state for `lock_count`+1 cycles.
- R12: The block ignores requests while in Idle, Stop or relock. It also ignores a request for Idle while in Slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Fast clock from the phase-locked loop |
| clk_osc | input | 1 | Free-running low-frequency oscillator; clocks the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| periph_en | input | NUM_PERIPH | Per-peripheral clock enables |
| lock_count | input | LOCK_W | Relock wait length in oscillator cycles, minus one |
| irq_pending | input | 1 | Any enabled interrupt pending (wakes Idle) |
| eint | input | NUM_EINT | External interrupt lines (wake Stop) |
| rtc_alarm | input | 1 | Real-time-clock alarm (wakes Stop) |
| cpu_clk | output | 1 | Gated CPU clock |
| periph_clk | output | NUM_PERIPH | Gated peripheral clocks |
| pll_en | output | 1 | Loop enable |
| mode_stat | output | 3 | Current state code |

## Verification
- **Clock rates:** the bench counts rising edges on every gated clock over fixed four-cycle windows. This shows whether a clock comes from the fast source, comes from the oscillator, or is stopped.
- **Peripheral enables:** all sixteen `periph_enable` patterns are swept in Normal. This catches swapped or merged enable bits.
- **Stop wake-up:** six lock counts are swept, with the wake coming alternately from each external line and from the alarm. This checks the exact relock length and separates a true wake from a stray interrupt or request.
- **Origin of Stop:** Stop is also entered from Slow, which separates the return-to-Slow path from the relock path.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_SLOW   = 3'd1,
        ST_IDLE   = 3'd2,
        ST_STOP   = 3'd3,
        ST_RELOCK = 3'd4
    } cps_state_e;

    localparam logic [1:0] REQ_NORMAL = 2'd0;
    localparam logic [1:0] REQ_SLOW   = 2'd1;
    localparam logic [1:0] REQ_IDLE   = 2'd2;
    localparam logic [1:0] REQ_STOP   = 2'd3;
endpackage

// File: rtl/cps_gate.sv
`timescale 1ns/1ps
module cps_gate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_lat;

    // enable captured only while the clock is low
    always_latch begin
        if (!clk_in) en_lat <= en;
    end

    assign clk_out = clk_in & en_lat;
endmodule

// File: rtl/cps_lock_timer.sv
`timescale 1ns/1ps
module cps_lock_timer #(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LOCK_W-1:0] load_val,
    output logic              done
);
    logic [LOCK_W-1:0] cnt;
    logic              busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= load_val;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    AST_LOCK_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0 && !start) |=> (cnt == $past(cnt) - 1'b1)); // R8

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy); // R8
endmodule

// File: rtl/cps_fsm.sv
`timescale 1ns/1ps
module cps_fsm
    import cps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       irq_pending,
    input  logic       wake_any,
    input  logic       lock_done,
    output logic       lock_start,
    output logic       sel_pll,
    output logic       sel_osc,
    output logic       cpu_on,
    output logic       per_on,
    output logic       pll_en,
    output logic [2:0] mode_stat
);
    cps_state_e state, nxt;
    logic       from_slow, from_slow_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_NORMAL;
            from_slow <= 1'b0;
        end else begin
            state     <= nxt;
            from_slow <= from_slow_nxt;
        end
    end

    always_comb begin
        nxt           = state;
        from_slow_nxt = from_slow;
        lock_start    = 1'b0;
        unique case (state)
            ST_NORMAL: begin
                if (req_valid) begin
                    if (req_mode == REQ_SLOW) nxt = ST_SLOW;
                    else if (req_mode == REQ_IDLE) nxt = ST_IDLE;
                    else if (req_mode == REQ_STOP) begin
                        nxt           = ST_STOP;
                        from_slow_nxt = 1'b0;
                    end
                end
            end
            ST_SLOW: begin
                if (req_valid) begin
                    if (req_mode == REQ_NORMAL) begin
                        nxt        = ST_RELOCK;
                        lock_start = 1'b1;
                    end else if (req_mode == REQ_STOP) begin
                        nxt           = ST_STOP;
                        from_slow_nxt = 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (irq_pending) nxt = ST_NORMAL;
            end
            ST_STOP: begin
                if (wake_any) begin
                    if (from_slow) nxt = ST_SLOW;
                    else begin
                        nxt        = ST_RELOCK;
                        lock_start = 1'b1;
                    end
                end
            end
            ST_RELOCK: begin
                if (lock_done) nxt = ST_NORMAL;
            end
            default: nxt = ST_NORMAL;
        endcase
    end

    always_comb begin
        sel_pll = (state == ST_NORMAL) || (state == ST_IDLE);
        sel_osc = (state == ST_SLOW);
        cpu_on  = (state == ST_NORMAL) || (state == ST_SLOW);
        per_on  = (state == ST_NORMAL) || (state == ST_SLOW) || (state == ST_IDLE);
        pll_en  = (state == ST_NORMAL) || (state == ST_IDLE) || (state == ST_RELOCK);
        mode_stat = state;
    end

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !wake_any) |=> (state == ST_STOP)); // R6

    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && irq_pending) |=> (state == ST_NORMAL)); // R7

    AST_RELOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELOCK && lock_done) |=> (state == ST_NORMAL)); // R8

    AST_SLOW_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && wake_any && from_slow) |=> (state == ST_SLOW)); // R9

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_NORMAL && state != ST_IDLE) |=> (state != ST_IDLE)); // R12
endmodule

// File: rtl/clk_power_seq.sv
`timescale 1ns/1ps
module clk_power_seq #(
    parameter int NUM_PERIPH = 4,
    parameter int NUM_EINT   = 8,
    parameter int LOCK_W     = 8
) (
    input  logic                  clk_pll,
    input  logic                  clk_osc,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_mode,
    input  logic [NUM_PERIPH-1:0] periph_en,
    input  logic [LOCK_W-1:0]     lock_count,
    input  logic                  irq_pending,
    input  logic [NUM_EINT-1:0]   eint,
    input  logic                  rtc_alarm,
    output logic                  cpu_clk,
    output logic [NUM_PERIPH-1:0] periph_clk,
    output logic                  pll_en,
    output logic [2:0]            mode_stat
);
    logic lock_start, lock_done;
    logic sel_pll, sel_osc, cpu_on, per_on;
    logic pll_g, osc_g, root_clk;
    logic wake_any;

    assign wake_any = (|eint) | rtc_alarm;

    cps_fsm u_fsm (
        .clk        (clk_osc),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .irq_pending(irq_pending),
        .wake_any   (wake_any),
        .lock_done  (lock_done),
        .lock_start (lock_start),
        .sel_pll    (sel_pll),
        .sel_osc    (sel_osc),
        .cpu_on     (cpu_on),
        .per_on     (per_on),
        .pll_en     (pll_en),
        .mode_stat  (mode_stat)
    );

    cps_lock_timer #(.LOCK_W(LOCK_W)) u_timer (
        .clk     (clk_osc),
        .rst_n   (rst_n),
        .start   (lock_start),
        .load_val(lock_count),
        .done    (lock_done)
    );

    cps_gate u_src_pll (.clk_in(clk_pll), .en(sel_pll), .clk_out(pll_g));
    cps_gate u_src_osc (.clk_in(clk_osc), .en(sel_osc), .clk_out(osc_g));
    assign root_clk = pll_g | osc_g;

    cps_gate u_cpu (.clk_in(root_clk), .en(cpu_on), .clk_out(cpu_clk));

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
        cps_gate u_pg (
            .clk_in (root_clk),
            .en     (per_on & periph_en[i]),
            .clk_out(periph_clk[i])
        );
    end

    AST_SRC_EXCLUSIVE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !(sel_pll && sel_osc)); // R3

    AST_STOP_CLOCKS_OFF: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (mode_stat == 3'd3) |-> (!pll_en && !cpu_on && !per_on)); // R5
endmodule

// File: tb/sim_clk_power_seq.sv
`timescale 1ns/1ps
module sim_clk_power_seq;
    logic clk_pll = 0, clk_osc = 0, rst_n = 0;
    logic req_valid = 0;
    logic [1:0] req_mode = 0;
    logic [3:0] periph_en = 4'hF;
    logic [7:0] lock_count = 8'd0;
    logic irq_pending = 0;
    logic [7:0] eint = 0;
    logic rtc_alarm = 0;
    logic cpu_clk, pll_en;
    logic [3:0] periph_clk;
    logic [2:0] mode_stat;

    always #2.5 clk_pll = ~clk_pll;   // 200 MHz
    always #20  clk_osc = ~clk_osc;

    clk_power_seq u0 (
        .clk_pll(clk_pll), .clk_osc(clk_osc), .rst_n(rst_n),
        .req_valid(req_valid), .req_mode(req_mode), .periph_en(periph_en),
        .lock_count(lock_count), .irq_pending(irq_pending), .eint(eint),
        .rtc_alarm(rtc_alarm), .cpu_clk(cpu_clk), .periph_clk(periph_clk),
        .pll_en(pll_en), .mode_stat(mode_stat)
    );

    int errs = 0, checks = 0;
    int cnt_cpu = 0, c0 = 0, c1 = 0, c2 = 0, c3 = 0;
    int d_cpu;
    int d_p [4];

    always @(posedge cpu_clk)       cnt_cpu++;
    always @(posedge periph_clk[0]) c0++;
    always @(posedge periph_clk[1]) c1++;
    always @(posedge periph_clk[2]) c2++;
    always @(posedge periph_clk[3]) c3++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit near(input int a, input int e);
        return (a >= e - 1) && (a <= e + 1);
    endfunction

    task automatic measure();
        int s, s0, s1, s2, s3;
        s = cnt_cpu; s0 = c0; s1 = c1; s2 = c2; s3 = c3;
        repeat (4) @(negedge clk_osc);
        d_cpu = cnt_cpu - s;
        d_p[0] = c0 - s0; d_p[1] = c1 - s1; d_p[2] = c2 - s2; d_p[3] = c3 - s3;
    endtask

    task automatic do_req(input logic [1:0] m);
        req_valid = 1; req_mode = m;
        @(negedge clk_osc);
        req_valid = 0;
    endtask

    task automatic wait_relock(output int n, output int cpu_e, output bit pll_ok);
        int base;
        base = cnt_cpu; n = 0; cpu_e = 0; pll_ok = 1;
        while (mode_stat == 3'd4 && n < 100) begin
            n++;
            cpu_e = cnt_cpu - base;
            if (!pll_en) pll_ok = 0;
            @(negedge clk_osc);
        end
    endtask

    initial begin
        #500000;
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n, ce;
        bit pok;
        repeat (3) @(negedge clk_osc);
        rst_n = 1;
        chk(mode_stat == 0, "R1 reset mode", mode_stat, 0);
        chk(pll_en == 1, "R1 reset pll_en", pll_en, 1);
        measure();
        chk(near(d_cpu, 32), "R1 cpu rate", d_cpu, 32);

        // R10: exhaustive sweep of peripheral enables in Normal
        for (int pat = 0; pat < 16; pat++) begin
            periph_en = pat[3:0];
            @(negedge clk_osc);
            measure();
            for (int i = 0; i < 4; i++) begin
                int e;
                e = pat[i] ? 32 : 0;
                chk(near(d_p[i], e), "R10 periph gate", d_p[i], e);
            end
        end
        periph_en = 4'hF;

        // Slow mode
        do_req(2'd1);
        chk(mode_stat == 1, "R2 slow status", mode_stat, 1);
        chk(pll_en == 0, "R3 slow pll off", pll_en, 0);
        measure();
        chk(near(d_cpu, 4), "R3 cpu at osc rate", d_cpu, 4);
        chk(near(d_p[2], 4), "R3 periph at osc rate", d_p[2], 4);
        do_req(2'd2);
        chk(mode_stat == 1, "R12 idle request ignored in slow", mode_stat, 1);

        // Slow -> Normal via relock
        lock_count = 8'd3;
        do_req(2'd0);
        wait_relock(n, ce, pok);
        chk(n == 4, "R11 relock length from slow", n, 4);
        chk(mode_stat == 0, "R11 back to normal", mode_stat, 0);

        // Idle mode
        periph_en = 4'b1010;
        do_req(2'd2);
        chk(mode_stat == 2, "R2 idle status", mode_stat, 2);
        measure();
        chk(d_cpu == 0, "R4 cpu stopped in idle", d_cpu, 0);
        for (int i = 0; i < 4; i++) begin
            int e;
            e = (i % 2 == 1) ? 32 : 0;
            chk(near(d_p[i], e), "R4 periph in idle", d_p[i], e);
        end
        do_req(2'd3);
        chk(mode_stat == 2, "R12 stop request ignored in idle", mode_stat, 2);
        irq_pending = 1;
        @(negedge clk_osc);
        irq_pending = 0;
        chk(mode_stat == 0, "R7 idle wake", mode_stat, 0);
        periph_en = 4'hF;

        // Stop from Normal, sweep lock counts and wake sources
        for (int L = 0; L < 6; L++) begin
            lock_count = L[7:0];
            do_req(2'd3);
            chk(mode_stat == 3, "R2 stop status", mode_stat, 3);
            chk(pll_en == 0, "R5 stop pll off", pll_en, 0);
            measure();
            chk(d_cpu == 0 && d_p[0] == 0 && d_p[3] == 0, "R5 clocks halted", d_cpu + d_p[0] + d_p[3], 0);
            irq_pending = 1;
            repeat (2) @(negedge clk_osc);
            irq_pending = 0;
            chk(mode_stat == 3, "R6 irq does not wake stop", mode_stat, 3);
            do_req(2'd0);
            chk(mode_stat == 3, "R12 request ignored in stop", mode_stat, 3);
            if (L % 2 == 0) eint = 8'd1 << L; else rtc_alarm = 1;
            @(negedge clk_osc);
            eint = 0; rtc_alarm = 0;
            wait_relock(n, ce, pok);
            chk(n == L + 1, "R8 relock length", n, L + 1);
            chk(ce == 0, "R8 cpu gated during relock", ce, 0);
            chk(pok, "R8 pll enabled during relock", pok, 1);
            chk(mode_stat == 0, "R8 normal after relock", mode_stat, 0);
        end

        // Stop from Slow
        do_req(2'd1);
        do_req(2'd3);
        chk(mode_stat == 3, "R9 stop from slow", mode_stat, 3);
        rtc_alarm = 1;
        @(negedge clk_osc);
        rtc_alarm = 0;
        chk(mode_stat == 1, "R9 wake returns to slow", mode_stat, 1);
        measure();
        chk(near(d_cpu, 4), "R9 cpu at osc rate after wake", d_cpu, 4);
        lock_count = 8'd1;
        do_req(2'd0);
        wait_relock(n, ce, pok);
        chk(n == 2, "R11 relock length", n, 2);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule